// File: doc/BRIEF.md
# Standby Clock Enable Controller

This block decides, every cycle of a fast reference clock, which parts of a small microcontroller may advance. It picks a timing source from three strobe inputs: a PLL-rate strobe used as is, an oscillator strobe halved, or a sub-oscillator strobe quartered. It turns the chosen rate into four registered clock enables: one for the CPU, one for the general peripherals, one for the time-base timer and one for the watch timer. The real oscillators, PLL lock and the peripherals sit outside. The block only models their rates as strobes and drives the two oscillator run enables.

Software writes an 8-bit control word to ask for a standby state. Sleep stops the CPU only. Timer-only keeps just the one timer that belongs to the selected source. Stop halts the active oscillator and every enable. The same word sets how strongly the CPU enable is thinned while running, and it can raise a one-cycle software reset request. An interrupt brings the block back to normal run; leaving stop first waits a fixed settle count. The block has no streaming data path, so every pin is a plain level or strobe, with no valid/ready handshake.

Control word layout, LSB = bit 0: bit 7 requests stop; bit 6 requests standby; bit 4 is an active-low reset request; bit 3 chooses, when low, timer-only in place of sleep; bits 2:1 are the thinning code; bits 5 and 0 are unused.

Top module: `lpm_clock_ctrl`

## Requirements
- R1: After reset, `ctl_rdata` reads 0x18, all four clock enables and `sw_rst` are low, and both oscillator enables are high.
- R2: `clk_sel` 00 uses every `pll_tick`; 10 uses every fourth `sub_tick`; 01 and 11 use every second `osc_tick`. An enable rises in the cycle after the edge that samples the chosen tick.
- R3: A write with bit 7 and bit 6 both set enters stop and not sleep.
- R4: In normal run, both `cpu_ce` and `per_ce` follow the base rate, apart from thinning (R9).
- R5: A write with bit 6 = 1 and bit 3 = 1 enters sleep. `cpu_ce` then stays low while `per_ce` keeps the base rate.
- R6: A write with bit 6 = 1 and bit 3 = 0 enters timer-only mode. `cpu_ce` and `per_ce` go low, and only `tbt_ce` (sources 00/01/11) or only `wt_ce` (source 10) keeps the base rate. `tbt_ce` and `wt_ce` are never high together.
- R7: In stop, all four enables are low. `main_osc_en` goes low when the oscillator or PLL source is selected, and `sub_osc_en` goes low when the sub source is selected.
- R8: `wake_irq` in stop turns the oscillator back on at once. The enables then stay low for SETTLE_CYC further cycles before normal run resumes.
- R9: The thinning code in bits 2:1 (0,1,2,3) blocks the first 0, 8, 16 or 32 base ticks of every 64 base ticks counted in run. `per_ce` is not thinned.
- R10: A write in run with bit 4 = 0 gives a one-cycle `sw_rst` pulse in the next cycle.
- R11: A standby or stop write made while `wake_irq` is high is dropped. `wake_irq` in sleep or timer-only returns to run at the next edge.
- R12: Writes outside normal run change nothing. Bits 7 and 6 always read back 0, bit 4 reads 1, and bits 3:1 read back the last value accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 2 | Source: 00 PLL, 01/11 oscillator/2, 10 sub/4 |
| pll_tick | input | 1 | PLL-rate strobe |
| osc_tick | input | 1 | Oscillator-rate strobe |
| sub_tick | input | 1 | Sub-oscillator-rate strobe |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 8 | Control word |
| wake_irq | input | 1 | Pending enabled interrupt |
| ctl_rdata | output | 8 | Control word readback |
| cpu_ce | output | 1 | CPU clock enable |
| per_ce | output | 1 | Peripheral clock enable |
| tbt_ce | output | 1 | Time-base timer clock enable |
| wt_ce | output | 1 | Watch timer clock enable |
| main_osc_en | output | 1 | Oscillator/PLL run enable |
| sub_osc_en | output | 1 | Sub-oscillator run enable |
| sw_rst | output | 1 | One-cycle software reset request |

## Verification
Strobes held constantly high separate the three source rates by counting enables over fixed windows: 20 cycles give 20, 10 or 5 pulses. The same constant PLL strobe with each thinning code shows the exact number of blocked CPU pulses in a 64-tick period. Directed writes then separate sleep, timer-only on both timer families, stop priority, a dropped request under a pending interrupt, and ignored writes during standby. The stop exit is timed to the exact settle length. A long random phase with sparse strobes, random control words, random interrupts and source changes is compared cycle by cycle against a behavioural model. This covers mode changes that land between divider phases.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_SLEEP  = 3'd1,
    ST_TIMER  = 3'd2,
    ST_STOP   = 3'd3,
    ST_SETTLE = 3'd4
  } lpm_state_e;

  // control word bit positions
  localparam int CTL_W       = 8;
  localparam int B_STOP      = 7;
  localparam int B_STANDBY   = 6;
  localparam int B_SWRST_N   = 4;
  localparam int B_TIMER_N   = 3;
  localparam int B_THIN_HI   = 2;
  localparam int B_THIN_LO   = 1;

  // source select codes
  localparam logic [1:0] SEL_PLL = 2'b00;
  localparam logic [1:0] SEL_SUB = 2'b10;

  typedef struct packed {
    logic stop;
    logic sleep;
    logic timer_only;
  } lpm_req_t;

  // number of blocked base ticks per thinning period
  function automatic int thin_len(input logic [1:0] code, input int unit);
    if (code == 2'd0) return 0;
    return unit << (int'(code) - 1);
  endfunction

endpackage

// File: rtl/lpm_tick_div.sv
module lpm_tick_div #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic pulse
);
  generate
    if (DIV < 2) begin : g_pass
      logic unused_pass;
      assign unused_pass = clk ^ rst_n;
      assign pulse = tick;
    end else begin : g_cnt
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt <= '0;
        end else if (tick) begin
          cnt <= (cnt == LAST) ? '0 : cnt + CW'(1);
        end
      end
      assign pulse = tick & (cnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/lpm_clk_src.sv
module lpm_clk_src import lpm_pkg::*; #(
  parameter int MAIN_DIV = 2,
  parameter int SUB_DIV  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] clk_sel,
  input  logic       pll_tick,
  input  logic       osc_tick,
  input  logic       sub_tick,
  output logic       base_tick,
  output logic       sub_sel
);
  logic main_pulse;
  logic sub_pulse;

  lpm_tick_div #(.DIV(MAIN_DIV)) u_main_div (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (osc_tick),
    .pulse (main_pulse)
  );

  lpm_tick_div #(.DIV(SUB_DIV)) u_sub_div (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (sub_tick),
    .pulse (sub_pulse)
  );

  always_comb begin
    case (clk_sel)
      SEL_PLL: base_tick = pll_tick;
      SEL_SUB: base_tick = sub_pulse;
      default: base_tick = main_pulse;
    endcase
  end

  assign sub_sel = (clk_sel == SEL_SUB);
endmodule

// File: rtl/lpm_thin.sv
module lpm_thin import lpm_pkg::*; #(
  parameter int PERIOD = 64,
  parameter int UNIT   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  input  logic [1:0] code,
  output logic       allow
);
  localparam int PW = $clog2(PERIOD);
  localparam logic [PW-1:0] LAST = PW'(PERIOD - 1);

  logic [PW-1:0] pos;
  logic [31:0]   pos_w;
  logic [31:0]   lim_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0;
    end else if (adv) begin
      pos <= (pos == LAST) ? '0 : pos + PW'(1);
    end
  end

  assign pos_w = 32'(pos);
  assign lim_w = 32'(thin_len(code, UNIT));
  assign allow = (pos_w >= lim_w);
endmodule

// File: rtl/lpm_ctl_reg.sv
module lpm_ctl_reg import lpm_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  input  logic             accept,
  output lpm_req_t         req,
  output logic [1:0]       thin_code,
  output logic             sw_rst,
  output logic [CTL_W-1:0] rdata
);
  logic take;
  logic timer_n_q;
  logic [1:0] code_q;
  logic swr_q;
  logic unused_bits;

  assign take = wr_en & accept;
  assign unused_bits = wr_data[5] ^ wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer_n_q <= 1'b1;
      code_q    <= 2'd0;
      swr_q     <= 1'b0;
    end else begin
      swr_q <= take & ~wr_data[B_SWRST_N];
      if (take) begin
        timer_n_q <= wr_data[B_TIMER_N];
        code_q    <= wr_data[B_THIN_HI:B_THIN_LO];
      end
    end
  end

  always_comb begin
    req.stop       = take & wr_data[B_STOP];
    req.sleep      = take & ~wr_data[B_STOP] & wr_data[B_STANDBY] & wr_data[B_TIMER_N];
    req.timer_only = take & ~wr_data[B_STOP] & wr_data[B_STANDBY] & ~wr_data[B_TIMER_N];
  end

  always_comb begin
    rdata                       = '0;
    rdata[B_SWRST_N]            = 1'b1;
    rdata[B_TIMER_N]            = timer_n_q;
    rdata[B_THIN_HI:B_THIN_LO]  = code_q;
  end

  assign thin_code = code_q;
  assign sw_rst    = swr_q;
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm import lpm_pkg::*; #(
  parameter int SETTLE_CYC = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  lpm_req_t   req,
  input  logic       wake_irq,
  output lpm_state_e st
);
  localparam int SW = $clog2(SETTLE_CYC + 1);
  localparam logic [SW-1:0] LAST = SW'(SETTLE_CYC - 1);

  logic [SW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_RUN;
      cnt <= '0;
    end else begin
      case (st)
        ST_RUN: begin
          if (!wake_irq) begin
            if (req.stop)            st <= ST_STOP;
            else if (req.timer_only) st <= ST_TIMER;
            else if (req.sleep)      st <= ST_SLEEP;
          end
        end
        ST_SLEEP, ST_TIMER: begin
          if (wake_irq) st <= ST_RUN;
        end
        ST_STOP: begin
          if (wake_irq) begin
            st  <= ST_SETTLE;
            cnt <= '0;
          end
        end
        ST_SETTLE: begin
          if (cnt == LAST) st  <= ST_RUN;
          else             cnt <= cnt + SW'(1);
        end
        default: st <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/lpm_clock_ctrl.sv
module lpm_clock_ctrl import lpm_pkg::*; #(
  parameter int MAIN_DIV    = 2,
  parameter int SUB_DIV     = 4,
  parameter int THIN_PERIOD = 64,
  parameter int THIN_UNIT   = 8,
  parameter int SETTLE_CYC  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] clk_sel,
  input  logic       pll_tick,
  input  logic       osc_tick,
  input  logic       sub_tick,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       wake_irq,
  output logic [7:0] ctl_rdata,
  output logic       cpu_ce,
  output logic       per_ce,
  output logic       tbt_ce,
  output logic       wt_ce,
  output logic       main_osc_en,
  output logic       sub_osc_en,
  output logic       sw_rst
);
  lpm_state_e st;
  lpm_req_t   req;
  logic [1:0] thin_code;
  logic       base_tick;
  logic       sub_sel;
  logic       allow;
  logic       in_run;
  logic       per_live;
  logic       tmr_live;
  logic       halted;

  assign in_run   = (st == ST_RUN);
  assign per_live = (st == ST_RUN) || (st == ST_SLEEP);
  assign tmr_live = per_live || (st == ST_TIMER);
  assign halted   = (st == ST_STOP);

  lpm_ctl_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .accept    (in_run),
    .req       (req),
    .thin_code (thin_code),
    .sw_rst    (sw_rst),
    .rdata     (ctl_rdata)
  );

  lpm_clk_src #(.MAIN_DIV(MAIN_DIV), .SUB_DIV(SUB_DIV)) u_src (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_sel   (clk_sel),
    .pll_tick  (pll_tick),
    .osc_tick  (osc_tick),
    .sub_tick  (sub_tick),
    .base_tick (base_tick),
    .sub_sel   (sub_sel)
  );

  lpm_thin #(.PERIOD(THIN_PERIOD), .UNIT(THIN_UNIT)) u_thin (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (base_tick & in_run),
    .code  (thin_code),
    .allow (allow)
  );

  lpm_fsm #(.SETTLE_CYC(SETTLE_CYC)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .wake_irq (wake_irq),
    .st       (st)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_ce <= 1'b0;
      per_ce <= 1'b0;
      tbt_ce <= 1'b0;
      wt_ce  <= 1'b0;
    end else begin
      cpu_ce <= in_run & base_tick & allow;
      per_ce <= per_live & base_tick;
      tbt_ce <= tmr_live & base_tick & ~sub_sel;
      wt_ce  <= tmr_live & base_tick & sub_sel;
    end
  end

  assign main_osc_en = ~(halted & ~sub_sel);
  assign sub_osc_en  = ~(halted & sub_sel);
endmodule

// File: rtl/lpm_clock_ctrl_chk.sv
module lpm_clock_ctrl_chk import lpm_pkg::*; (
  input logic       clk,
  input logic       rst_n,
  input lpm_state_e st,
  input logic       wr_en,
  input logic       cpu_ce,
  input logic       per_ce,
  input logic       tbt_ce,
  input logic       wt_ce,
  input logic       sw_rst
);
  AST_CPU_ONLY_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ce |-> $past(st == ST_RUN)); // R4
  AST_CPU_WITH_PER: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ce |-> per_ce); // R5
  AST_ONE_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tbt_ce, wt_ce})); // R6
  AST_STOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STOP && $past(st == ST_STOP)) |-> !(cpu_ce || per_ce || tbt_ce || wt_ce)); // R7
  AST_SETTLE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SETTLE) |=> (st == ST_SETTLE || st == ST_RUN)); // R8
  AST_SWRST_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |-> $past(wr_en)); // R10
endmodule

bind lpm_clock_ctrl lpm_clock_ctrl_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .st     (st),
  .wr_en  (wr_en),
  .cpu_ce (cpu_ce),
  .per_ce (per_ce),
  .tbt_ce (tbt_ce),
  .wt_ce  (wt_ce),
  .sw_rst (sw_rst)
);

// File: tb/tb_lpm_clock_ctrl.sv
`timescale 1ns/1ps
module tb_lpm_clock_ctrl;
  localparam int SETTLE = 16;
  localparam int WD_LIMIT = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] clk_sel = 2'b00;
  logic pll_tick = 1'b0, osc_tick = 1'b0, sub_tick = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic wake_irq = 1'b0;
  logic [7:0] ctl_rdata;
  logic cpu_ce, per_ce, tbt_ce, wt_ce, main_osc_en, sub_osc_en, sw_rst;

  int checks = 0;
  int errors = 0;
  int tick_mode = 1;
  bit done = 0;

  always #10 clk = ~clk;

  lpm_clock_ctrl dut (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .pll_tick(pll_tick),
    .osc_tick(osc_tick), .sub_tick(sub_tick), .wr_en(wr_en), .wr_data(wr_data),
    .wake_irq(wake_irq), .ctl_rdata(ctl_rdata), .cpu_ce(cpu_ce), .per_ce(per_ce),
    .tbt_ce(tbt_ce), .wt_ce(wt_ce), .main_osc_en(main_osc_en),
    .sub_osc_en(sub_osc_en), .sw_rst(sw_rst)
  );

  // behavioural reference model: 0 run, 1 sleep, 2 timer, 3 stop, 4 settle
  int mst, mcm, mcs, mpos, mset, mcg, mtn, lim;
  bit e_cpu, e_per, e_tbt, e_wt, e_swr, msub, mbase;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst = 0; mcm = 0; mcs = 0; mpos = 0; mset = 0; mcg = 0; mtn = 1;
      e_cpu = 0; e_per = 0; e_tbt = 0; e_wt = 0; e_swr = 0;
    end else begin
      int nst;
      msub = (clk_sel == 2'b10);
      if (clk_sel == 2'b00) mbase = pll_tick;
      else if (msub)        mbase = sub_tick && (mcs == 3);
      else                  mbase = osc_tick && (mcm == 1);
      lim = (mcg == 0) ? 0 : (8 << (mcg - 1));
      e_cpu = (mst == 0) && mbase && (mpos >= lim);
      e_per = (mst <= 1) && mbase;
      e_tbt = (mst <= 2) && mbase && !msub;
      e_wt  = (mst <= 2) && mbase && msub;
      e_swr = (mst == 0) && wr_en && !wr_data[4];
      if (osc_tick) mcm = (mcm + 1) % 2;
      if (sub_tick) mcs = (mcs + 1) % 4;
      if (mbase && mst == 0) mpos = (mpos + 1) % 64;
      nst = mst;
      case (mst)
        0: if (wr_en) begin
             if (!wake_irq) begin
               if (wr_data[7])      nst = 3;
               else if (wr_data[6]) nst = wr_data[3] ? 1 : 2;
             end
             mtn = wr_data[3];
             mcg = int'(wr_data[2:1]);
           end
        1, 2: if (wake_irq) nst = 0;
        3: if (wake_irq) begin nst = 4; mset = 0; end
        default: if (mset == SETTLE - 1) nst = 0; else mset = mset + 1;
      endcase
      mst = nst;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit [7:0] erd;
    bit emo, eso;
    erd = {3'b000, 1'b1, mtn[0], mcg[1:0], 1'b0};
    emo = !(mst == 3 && clk_sel != 2'b10);
    eso = !(mst == 3 && clk_sel == 2'b10);
    chk(cpu_ce == e_cpu, "R4 cpu_ce", cpu_ce, e_cpu);
    chk(per_ce == e_per, "R5 per_ce", per_ce, e_per);
    chk(tbt_ce == e_tbt, "R6 tbt_ce", tbt_ce, e_tbt);
    chk(wt_ce == e_wt, "R6 wt_ce", wt_ce, e_wt);
    chk(main_osc_en == emo, "R7 main_osc_en", main_osc_en, emo);
    chk(sub_osc_en == eso, "R7 sub_osc_en", sub_osc_en, eso);
    chk(sw_rst == e_swr, "R10 sw_rst", sw_rst, e_swr);
    chk(ctl_rdata == erd, "R12 ctl_rdata", ctl_rdata, erd);
  endtask

  task automatic cycle();
    @(negedge clk);
    compare_all();
    if (tick_mode == 1) begin
      pll_tick = 1; osc_tick = 1; sub_tick = 1;
    end else begin
      pll_tick = $urandom_range(0, 1);
      osc_tick = $urandom_range(0, 1);
      sub_tick = $urandom_range(0, 1);
    end
  endtask

  task automatic write(input logic [7:0] d);
    wr_en = 1; wr_data = d;
    cycle();
    wr_en = 0; wr_data = 8'h18;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=%0d expected<%0d cycles", WD_LIMIT, WD_LIMIT);
    finish_run();
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk(ctl_rdata == 8'h18, "R1 reset rdata", ctl_rdata, 8'h18);
    chk({cpu_ce, per_ce, tbt_ce, wt_ce, sw_rst} == 5'b0, "R1 reset enables",
        {cpu_ce, per_ce, tbt_ce, wt_ce, sw_rst}, 0);
    chk(main_osc_en && sub_osc_en, "R1 reset osc", {main_osc_en, sub_osc_en}, 3);
    tick_mode = 1;
    pll_tick = 1; osc_tick = 1; sub_tick = 1;
    idle(4);

    // R2 rates
    clk_sel = 2'b00; idle(4); cnt = 0;
    for (int i = 0; i < 20; i++) begin cycle(); cnt += per_ce; end
    chk(cnt == 20, "R2 pll rate", cnt, 20);
    clk_sel = 2'b01; idle(4); cnt = 0;
    for (int i = 0; i < 20; i++) begin cycle(); cnt += per_ce; end
    chk(cnt == 10, "R2 main rate", cnt, 10);
    clk_sel = 2'b10; idle(4); cnt = 0;
    for (int i = 0; i < 20; i++) begin cycle(); cnt += per_ce; end
    chk(cnt == 5, "R2 sub rate", cnt, 5);
    clk_sel = 2'b00; idle(2);

    // R9 thinning per code
    for (int c = 0; c < 4; c++) begin
      int lm;
      lm = (c == 0) ? 0 : (8 << (c - 1));
      write(8'h18 | 8'(c << 1));
      idle(70); cnt = 0;
      for (int i = 0; i < 64; i++) begin cycle(); cnt += cpu_ce; end
      chk(cnt == 64 - lm, "R9 thinned cpu count", cnt, 64 - lm);
    end
    write(8'h18); idle(3);
    chk(cpu_ce == 1, "R4 run cpu", cpu_ce, 1);

    // R5 sleep
    write(8'h58); idle(2);
    chk(cpu_ce == 0 && per_ce == 1, "R5 sleep", {cpu_ce, per_ce}, 2'b01);
    // R12 write while asleep ignored
    write(8'h1E); idle(2);
    chk(ctl_rdata == 8'h18, "R12 write ignored", ctl_rdata, 8'h18);
    wake_irq = 1; cycle(); wake_irq = 0; idle(2);
    chk(cpu_ce == 1, "R11 wake from sleep", cpu_ce, 1);

    // R6 timer-only, both sources
    write(8'h50); idle(2);
    chk(tbt_ce == 1 && per_ce == 0 && cpu_ce == 0, "R6 tbt only",
        {tbt_ce, per_ce, cpu_ce}, 3'b100);
    wake_irq = 1; cycle(); wake_irq = 0; idle(2);
    clk_sel = 2'b10; idle(2);
    write(8'h50); idle(2); cnt = 0;
    for (int i = 0; i < 8; i++) begin
      cycle(); cnt += wt_ce;
      chk(per_ce == 0 && tbt_ce == 0, "R6 watch only", {per_ce, tbt_ce}, 0);
    end
    chk(cnt == 2, "R6 watch rate", cnt, 2);
    wake_irq = 1; cycle(); wake_irq = 0; idle(2);
    clk_sel = 2'b00; idle(2);

    // R3 priority, R7 stop, R8 settle
    write(8'hD8); idle(2);
    chk(main_osc_en == 0 && per_ce == 0, "R3 stop wins", {main_osc_en, per_ce}, 0);
    chk(sub_osc_en == 1, "R7 sub osc kept", sub_osc_en, 1);
    wake_irq = 1; cycle(); wake_irq = 0;
    chk(main_osc_en == 1, "R8 osc restarts", main_osc_en, 1);
    cnt = 0;
    while (per_ce == 0 && cnt < 100) begin cnt++; cycle(); end
    chk(cnt == SETTLE + 1, "R8 settle length", cnt, SETTLE + 1);

    // R11 request dropped under pending interrupt
    wake_irq = 1; write(8'h58); wake_irq = 0; idle(2);
    chk(cpu_ce == 1, "R11 request dropped", cpu_ce, 1);

    // R10 software reset pulse
    write(8'h08);
    chk(sw_rst == 1, "R10 pulse", sw_rst, 1);
    cycle();
    chk(sw_rst == 0, "R10 one cycle", sw_rst, 0);

    // random phase
    tick_mode = 0;
    for (int i = 0; i < 4000; i++) begin
      wake_irq = ($urandom_range(0, 9) == 0);
      if ($urandom_range(0, 49) == 0) clk_sel = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 11) == 0) begin
        wr_en = 1; wr_data = 8'($urandom_range(0, 255));
      end else begin
        wr_en = 0;
      end
      cycle();
    end
    wr_en = 0; wake_irq = 0;
    idle(4);
    finish_run();
  end
endmodule